// File: doc/BRIEF.md
# Registered 8-Bit ALU with Result-Class Flags

This block is a small arithmetic and logic unit for a simple datapath. Each clock cycle it accepts two operands, an operation code and the current contents of the multiplier's shift register. On the next rising edge it presents the registered result. A flag generator then classifies that registered result. It reports whether the result is zero, odd or even. It also raises a carry flag for an addition that goes past the top of the range and a borrow flag for a subtraction that goes below zero. A further flag reports that the shift register held nothing.

The flags are derived from the stored result, so they are registered one stage later. They therefore belong to the operation issued two cycles earlier. The pipeline accepts a new operation every cycle. The result path and the flag path run independently, so back-to-back operations never stall. The adder is chosen by a parameter: an explicit ripple chain or a plain behavioural sum.

Top module: `alu_flagged`

## Requirements
- R1: While `rst_n` is low, `res_o` and every flag output are 0.
- R2: Operation code 0 yields (A + B) mod 256 and code 1 yields (A − B) mod 256 on `res_o` at the first rising edge after the operands are sampled.
- R3: Codes 2 to 7 yield, in that order, A AND B, A NAND B, A OR B, A NOR B, A XOR B and A XNOR B on `res_o` one cycle after sampling.
- R4: Code 8 yields the bitwise inverse of A, and the value on B has no effect on the result.
- R5: Codes 9 to 15 are unused. They yield a zero result, and both the carry and the borrow flags are cleared.
- R6: `zero_o` is 1 exactly when the result of the operation is all zeros.
- R7: `odd_o` is 1 when result bit 0 is 1 and the result is nonzero. `even_o` is 1 when result bit 0 is 0 and the result is nonzero. A zero result clears both flags.
- R8: `carry_o` is 1 exactly for code 0 when A + B exceeds 255. It is 0 for every other code.
- R9: `borrow_o` is 1 exactly for code 1 when B is greater than A. It is 0 for every other code.
- R10: `sr_zero_o` is 1 exactly when `mul_sr_i` was all zeros in the cycle the operands were sampled.
- R11: All flags for an operation appear one cycle after its result, which is two rising edges after the operands are sampled. They stay aligned with that operation when operations are issued back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (see R2 to R5) |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| mul_sr_i | input | 8 | Current multiplier shift register contents |
| res_o | output | 8 | Registered result, one cycle after the operands |
| zero_o | output | 1 | Result was zero |
| odd_o | output | 1 | Result nonzero with bit 0 set |
| even_o | output | 1 | Result nonzero with bit 0 clear |
| carry_o | output | 1 | Addition went past 255 |
| borrow_o | output | 1 | Subtraction went below zero |
| sr_zero_o | output | 1 | Shift register was empty |

## Verification
An operation driven before rising edge k must show its result after edge k and its flags after edge k+1. The driver task issues one operation per cycle and pushes the expected item into a queue. The monitor samples two nanoseconds after every rising edge. It pops one item per edge to compare `res_o`, then holds that item for exactly one more edge before comparing the flags. A flag that arrives one cycle early or late is therefore compared against the neighbouring operation and reported. Directed vectors cover the range boundaries, the zero result and operand B being ignored by inversion. A long run of random back-to-back operations then stresses the alignment.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_NAND = 4'd3,
      OP_OR   = 4'd4,
      OP_NOR  = 4'd5,
      OP_XOR  = 4'd6,
      OP_XNOR = 4'd7,
      OP_NOT  = 4'd8
   } alu_op_e;

   function automatic logic is_logic_op(input logic [OP_W-1:0] op);
      return (op >= OP_AND) && (op <= OP_NOT);
   endfunction

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
   parameter int WIDTH        = 8,
   parameter bit RIPPLE_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   logic [WIDTH-1:0] b_eff;

   assign b_eff = b_i ^ {WIDTH{sub_i}};

   generate
      if (RIPPLE_ADDER) begin : g_ripple
         logic [WIDTH:0] c;
         assign c[0] = sub_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic p;
            assign p          = a_i[i] ^ b_eff[i];
            assign sum_o[i]   = p ^ c[i];
            assign c[i+1]     = (a_i[i] & b_eff[i]) | (c[i] & p);
         end
         assign cout_o = c[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] full;
         assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
         assign sum_o  = full[WIDTH-1:0];
         assign cout_o = full[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_flag_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] y_o
);

   logic [WIDTH-1:0] and_v, or_v, xor_v;

   assign and_v = a_i & b_i;
   assign or_v  = a_i | b_i;
   assign xor_v = a_i ^ b_i;

   always_comb begin
      unique case (op_i)
         OP_AND:  y_o = and_v;
         OP_NAND: y_o = ~and_v;
         OP_OR:   y_o = or_v;
         OP_NOR:  y_o = ~or_v;
         OP_XOR:  y_o = xor_v;
         OP_XNOR: y_o = ~xor_v;
         OP_NOT:  y_o = ~a_i;
         default: y_o = '0;
      endcase
   end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] res_i,
   input  logic             carry_i,
   input  logic             borrow_i,
   input  logic             srz_i,
   output logic             zero_o,
   output logic             odd_o,
   output logic             even_o,
   output logic             carry_o,
   output logic             borrow_o,
   output logic             sr_zero_o
);

   logic nz;

   assign nz = |res_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_o    <= 1'b0;
         odd_o     <= 1'b0;
         even_o    <= 1'b0;
         carry_o   <= 1'b0;
         borrow_o  <= 1'b0;
         sr_zero_o <= 1'b0;
      end else begin
         zero_o    <= ~nz;
         odd_o     <= nz & res_i[0];
         even_o    <= nz & ~res_i[0];
         carry_o   <= carry_i;
         borrow_o  <= borrow_i;
         sr_zero_o <= srz_i;
      end
   end

   AST_PARITY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(odd_o && even_o)); // R7
   AST_ZERO_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o |-> (!odd_o && !even_o)); // R7
   AST_RANGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(carry_o && borrow_o)); // R8
   AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (zero_o == ($past(res_i) == '0))); // R6
   AST_SRZ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sr_zero_o == $past(srz_i))); // R11

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
   import alu_flag_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter int SR_WIDTH     = 8,
   parameter bit RIPPLE_ADDER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OP_W-1:0]     op_i,
   input  logic [WIDTH-1:0]    a_i,
   input  logic [WIDTH-1:0]    b_i,
   input  logic [SR_WIDTH-1:0] mul_sr_i,
   output logic [WIDTH-1:0]    res_o,
   output logic                zero_o,
   output logic                odd_o,
   output logic                even_o,
   output logic                carry_o,
   output logic                borrow_o,
   output logic                sr_zero_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_flagged: WIDTH must be at least 2");
      end
      if (SR_WIDTH < 1) begin : g_bad_sr
         $error("alu_flagged: SR_WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] sum, logic_y, res_d, res_q;
   logic             cout, is_sub, is_add;
   logic             carry_d, borrow_d, carry_q, borrow_q, srz_q;

   assign is_add = (op_i == OP_ADD);
   assign is_sub = (op_i == OP_SUB);

   alu_arith_unit #(
      .WIDTH        (WIDTH),
      .RIPPLE_ADDER (RIPPLE_ADDER)
   ) u_arith (
      .a_i    (a_i),
      .b_i    (b_i),
      .sub_i  (is_sub),
      .sum_o  (sum),
      .cout_o (cout)
   );

   alu_logic_unit #(
      .WIDTH (WIDTH)
   ) u_logic (
      .op_i (op_i),
      .a_i  (a_i),
      .b_i  (b_i),
      .y_o  (logic_y)
   );

   always_comb begin
      res_d    = '0;
      carry_d  = 1'b0;
      borrow_d = 1'b0;
      if (is_add || is_sub) begin
         res_d    = sum;
         carry_d  = is_add & cout;
         borrow_d = is_sub & ~cout;
      end else if (is_logic_op(op_i)) begin
         res_d = logic_y;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q    <= '0;
         carry_q  <= 1'b0;
         borrow_q <= 1'b0;
         srz_q    <= 1'b0;
      end else begin
         res_q    <= res_d;
         carry_q  <= carry_d;
         borrow_q <= borrow_d;
         srz_q    <= ~|mul_sr_i;
      end
   end

   assign res_o = res_q;

   alu_flag_gen #(
      .WIDTH (WIDTH)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_i     (res_q),
      .carry_i   (carry_q),
      .borrow_i  (borrow_q),
      .srz_i     (srz_q),
      .zero_o    (zero_o),
      .odd_o     (odd_o),
      .even_o    (even_o),
      .carry_o   (carry_o),
      .borrow_o  (borrow_o),
      .sr_zero_o (sr_zero_o)
   );

   AST_NOT_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_NOT) |=> (res_q == ~$past(a_i))); // R4
   AST_CARRY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_ADD) |=> (carry_q == (({1'b0, $past(a_i)} + {1'b0, $past(b_i)}) > (WIDTH+1)'((1 << WIDTH) - 1)))); // R8
   AST_BORROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SUB) |=> (borrow_q == ($past(b_i) > $past(a_i)))); // R9
   AST_UNUSED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > OP_NOT) |=> (res_q == '0 && !carry_q && !borrow_q)); // R5

endmodule

// File: tb/sim_alu_flagged.sv
module sim_alu_flagged;

   typedef struct {
      logic [7:0] res;
      logic       zero, odd, even, carry, borrow, srz;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = '0;
   logic [7:0] a_i = '0, b_i = '0, mul_sr_i = 8'h01;
   logic [7:0] res_o;
   logic       zero_o, odd_o, even_o, carry_o, borrow_o, sr_zero_o;

   int   checks = 0;
   int   failures = 0;
   bit   done = 0;
   exp_t exp_q[$];
   exp_t pend;
   bit   pend_v = 0;

   always #5 clk = ~clk;

   alu_flagged u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .mul_sr_i(mul_sr_i), .res_o(res_o), .zero_o(zero_o), .odd_o(odd_o),
      .even_o(even_o), .carry_o(carry_o), .borrow_o(borrow_o),
      .sr_zero_o(sr_zero_o)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                  input logic [7:0] b, input logic [7:0] sr,
                                  input string req);
      exp_t e;
      logic [8:0] full;
      e.carry = 0; e.borrow = 0; e.req = req;
      case (op)
         4'd0: begin full = {1'b0, a} + {1'b0, b}; e.res = full[7:0]; e.carry = full[8]; end
         4'd1: begin e.res = a - b; e.borrow = (b > a); end
         4'd2: e.res = a & b;
         4'd3: e.res = ~(a & b);
         4'd4: e.res = a | b;
         4'd5: e.res = ~(a | b);
         4'd6: e.res = a ^ b;
         4'd7: e.res = ~(a ^ b);
         4'd8: e.res = ~a;
         default: e.res = 8'h00;
      endcase
      e.zero = (e.res == 0);
      e.odd  = e.res[0] && (e.res != 0);
      e.even = !e.res[0] && (e.res != 0);
      e.srz  = (sr == 0);
      return e;
   endfunction

   task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] sr, input string req);
      @(negedge clk);
      op_i = op; a_i = a; b_i = b; mul_sr_i = sr;
      exp_q.push_back(model(op, a, b, sr, req));
   endtask

   // Monitor: result one edge after sampling, flags one edge after the result (R11)
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (!rst_n) begin
            pend_v = 0;
         end else begin
            if (pend_v) begin
               chk({7'b0, zero_o},    {7'b0, pend.zero},   {"R6,R11 zero ", pend.req});
               chk({7'b0, odd_o},     {7'b0, pend.odd},    {"R7,R11 odd ", pend.req});
               chk({7'b0, even_o},    {7'b0, pend.even},   {"R7,R11 even ", pend.req});
               chk({7'b0, carry_o},   {7'b0, pend.carry},  {"R8,R11 carry ", pend.req});
               chk({7'b0, borrow_o},  {7'b0, pend.borrow}, {"R9,R11 borrow ", pend.req});
               chk({7'b0, sr_zero_o}, {7'b0, pend.srz},    {"R10,R11 srzero ", pend.req});
               pend_v = 0;
            end
            if (exp_q.size() > 0) begin
               pend = exp_q.pop_front();
               chk(res_o, pend.res, {"result ", pend.req});
               pend_v = 1;
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs held at zero during reset
      chk(res_o, 8'h00, "R1 reset result");
      chk({2'b0, zero_o, odd_o, even_o, carry_o, borrow_o, sr_zero_o}, 8'h00, "R1 reset flags");
      rst_n = 1'b1;

      drive(4'd0, 8'd100, 8'd55,  8'h03, "R2 add");
      drive(4'd0, 8'd200, 8'd56,  8'h03, "R2 R8 add wraps to zero");
      drive(4'd0, 8'd255, 8'd0,   8'h00, "R8 add at top no carry");
      drive(4'd0, 8'd255, 8'd1,   8'h00, "R8 add just past top");
      drive(4'd1, 8'd9,   8'd9,   8'h10, "R2 R6 sub equal");
      drive(4'd1, 8'd3,   8'd4,   8'h10, "R9 sub below zero");
      drive(4'd1, 8'd200, 8'd7,   8'h00, "R9 sub no borrow");
      drive(4'd2, 8'hF0,  8'h3C,  8'h01, "R3 and");
      drive(4'd3, 8'hF0,  8'h3C,  8'h01, "R3 nand");
      drive(4'd4, 8'hF0,  8'h0C,  8'h01, "R3 or");
      drive(4'd5, 8'h00,  8'h00,  8'h01, "R3 nor");
      drive(4'd6, 8'hAA,  8'hAA,  8'h01, "R3 R7 xor zero");
      drive(4'd7, 8'hA5,  8'h0F,  8'h01, "R3 xnor");
      drive(4'd8, 8'h5A,  8'h00,  8'h01, "R4 not b=00");
      drive(4'd8, 8'h5A,  8'hFF,  8'h01, "R4 not b=FF ignored");
      drive(4'd8, 8'hFF,  8'h12,  8'h00, "R4 R6 not to zero");
      drive(4'd9, 8'hFF,  8'hFF,  8'h01, "R5 unused code 9");
      drive(4'd15, 8'h80, 8'h80,  8'h00, "R5 unused code 15");
      drive(4'd0, 8'd1,   8'd2,   8'h80, "R7 odd result");
      drive(4'd0, 8'd1,   8'd1,   8'h80, "R7 even result");
      drive(4'd0, 8'd255, 8'd255, 8'h00, "R8 R10 max add");

      for (int i = 0; i < 400; i++) begin
         logic [7:0] ra, rb, rs;
         ra = 8'($urandom);
         rb = (i % 7 == 0) ? ra : 8'($urandom);
         rs = (i % 5 == 0) ? 8'h00 : 8'($urandom);
         drive(4'($urandom_range(0, 15)), ra, rb, rs, "R2 R3 R11 random");
      end

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule